// File: doc/BRIEF.md
# In-Order Instruction Completion Queue

This block keeps a record of every dispatched instruction in program order. It lets the instructions leave the record only in that same order. A dispatch stage asks for up to three slots in a cycle. The block grants as many as fit and returns the slot number of the first one. The other granted lanes take the next slot numbers in turn. Execution units later report a slot as finished, and they may flag an exception with that report. A branch unit reports each branch outcome against the branch's slot.

In each cycle the block retires a run of up to three slots, beginning with the oldest, and stops at the first slot that may not leave yet. A slot that finished with an exception halts retirement. When that slot becomes the oldest, the block reports its slot number and discards every tracked instruction, which keeps exceptions precise. A mispredicted branch discards only the slots younger than the branch, and the next free slot moves back to just after the branch in the same cycle.

Top module: `retire_queue`

## Requirements
- R1: The queue holds 16 entries. `full` is 1 exactly when 16 entries are held. While full, no dispatch is accepted unless entries retire in the same cycle.
- R2: The accepted dispatch count `dispAccept` is the smaller of the request `dispNum` (0 to 3) and the free space, where free space is 16 minus the occupancy plus the entries retiring in this cycle. The count is 0 in a cycle with an exception flush or a misprediction. Lane k gets slot `dispTag`+k modulo 16, and `dispTag` is the slot just after the youngest entry.
- R3: `retCount` is the length of the run of eligible entries that starts at the oldest entry. An entry is eligible when it has finished without an exception and, if it is a branch, its outcome has been reported. Retirement is decoded from registered state, so a finish report in cycle n allows retirement in cycle n+1 at the earliest.
- R4: No more than three entries retire in one cycle.
- R5: `retTag` is the slot of the oldest entry. Retired slots leave in exactly the order they were dispatched.
- R6: A branch entry does not retire, even when finished, until a resolution for its slot has been reported.
- R7: A misprediction on a held, unresolved branch removes every younger entry in that cycle. The next `dispTag` is the branch slot plus 1, the branch itself stays, and dispatch is refused in that cycle.
- R8: A finish report for a slot that is not held, including a slot just removed by a flush, has no effect, and a later entry placed in that slot starts unfinished.
- R9: When the oldest entry has finished with an exception, `excValid` is 1, `excTag` gives its slot, nothing retires and nothing is dispatched. The queue is empty in the next cycle.
- R10: After reset the queue is empty, not full, and reports no retirement and no exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dispNum | input | 2 | Number of instructions requesting dispatch (0 to 3) |
| dispBranch | input | 3 | Per-lane flag: the lane holds a branch |
| dispAccept | output | 2 | Number of lanes accepted this cycle |
| dispTag | output | 4 | Slot given to lane 0 (the next free slot) |
| finValid | input | 1 | A finish report is present |
| finTag | input | 4 | Slot of the finished instruction |
| finExc | input | 1 | The finished instruction raised an exception |
| brValid | input | 1 | A branch resolution is present |
| brTag | input | 4 | Slot of the resolved branch |
| brMispredict | input | 1 | The branch was mispredicted |
| retCount | output | 2 | Entries retiring this cycle |
| retTag | output | 4 | Slot of the oldest entry (first retiring one) |
| excValid | output | 1 | Oldest entry faulted; all entries are flushed |
| excTag | output | 4 | Slot of the faulting entry |
| full | output | 1 | 16 entries held |
| empty | output | 1 | No entries held |

## Verification
Checks run on every cycle for these rules: occupancy never goes past 16, no grant while full and nothing leaving, no retirement while an exception sits at the head, a retiring head entry is both held and finished, and a retiring head branch is resolved. They also confirm that the queue is empty after an exception flush and that the occupancy after a misprediction equals the branch's distance from the head plus one. Two properties depend on the history of whole instruction streams: that retirement order matches dispatch order, and that stale finish reports cannot mark a reused slot. Only the bench's scoreboard and reference model can show these, using random finish latencies, exceptions and mispredictions.

// File: rtl/rq_pkg.sv
package rq_pkg;
  // dispatch and retire lanes per cycle
  localparam int LANES  = 3;
  localparam int LANE_W = $clog2(LANES + 1);

  typedef struct packed {
    logic              flushAll;  // exception at head: clear every entry
    logic              flushYng;  // mispredict: clear entries younger than brTag
    logic [LANE_W-1:0] allocCnt;  // entries written at the tail
    logic [LANE_W-1:0] retCnt;    // entries freed at the head
  } ctlStrobe_t;
endpackage

// File: rtl/rq_entries.sv
module rq_entries
  import rq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       ctl,
  input  logic [IDX_W-1:0] headIdx,
  input  logic [IDX_W-1:0] tailIdx,
  input  logic [LANES-1:0] dispBranch,
  input  logic             finValid,
  input  logic [IDX_W-1:0] finTag,
  input  logic             finExc,
  input  logic             brValid,
  input  logic [IDX_W-1:0] brTag,
  output logic [LANES-1:0] headElig,
  output logic             headExc,
  output logic             brHit
);
  logic [DEPTH-1:0] vld, done, exc, isBr, res, elig;
  logic [IDX_W-1:0] offH [DEPTH];
  logic [IDX_W-1:0] offT [DEPTH];
  logic [IDX_W-1:0] brOff;

  assign brOff = brTag - headIdx;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      offH[i] = IDX_W'(i) - headIdx;
      offT[i] = IDX_W'(i) - tailIdx;
      elig[i] = vld[i] & done[i] & ~exc[i] & (~isBr[i] | res[i]);
    end
  end

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      headElig[k] = elig[headIdx + IDX_W'(k)];
    end
  end

  assign headExc = vld[headIdx] & done[headIdx] & exc[headIdx];
  assign brHit   = vld[brTag] & isBr[brTag];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vld  <= '0;
      done <= '0;
      exc  <= '0;
      isBr <= '0;
      res  <= '0;
    end else if (ctl.flushAll) begin
      vld <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (offH[i] < IDX_W'(ctl.retCnt)) vld[i] <= 1'b0;
        if (ctl.flushYng && vld[i] && offH[i] > brOff) vld[i] <= 1'b0;
        if (finValid && finTag == IDX_W'(i) && vld[i]) begin
          done[i] <= 1'b1;
          exc[i]  <= finExc;
        end
        if (brValid && brTag == IDX_W'(i) && vld[i] && isBr[i]) res[i] <= 1'b1;
        if (offT[i] < IDX_W'(ctl.allocCnt)) begin
          vld[i]  <= 1'b1;
          done[i] <= 1'b0;
          exc[i]  <= 1'b0;
          isBr[i] <= dispBranch[offT[i][LANE_W-1:0]];
          res[i]  <= 1'b0;
        end
      end
    end
  end

  // R3
  head_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.retCnt != '0 |-> vld[headIdx] && done[headIdx] && !exc[headIdx]);
  // R6
  head_br_res_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.retCnt != '0 && isBr[headIdx]) |-> res[headIdx]);
endmodule

// File: rtl/rq_ctrl.sv
module rq_ctrl
  import rq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LANE_W-1:0] dispNum,
  input  logic              brValid,
  input  logic              brMispredict,
  input  logic [IDX_W-1:0]  brTag,
  input  logic              brHit,
  input  logic [LANES-1:0]  headElig,
  input  logic              headExc,
  output ctlStrobe_t        ctl,
  output logic [IDX_W-1:0]  headIdx,
  output logic [IDX_W-1:0]  tailIdx,
  output logic              full,
  output logic              empty
);
  localparam int PTR_W = IDX_W + 1;
  localparam int CNT_W = PTR_W + 1;

  logic [PTR_W-1:0]  headPtr, tailPtr, occ;
  logic [LANE_W-1:0] retCnt, accept;
  logic [CNT_W-1:0]  freeSlots;
  logic [IDX_W-1:0]  brOff;
  logic              excNow, misNow;

  assign headIdx = headPtr[IDX_W-1:0];
  assign tailIdx = tailPtr[IDX_W-1:0];
  assign occ     = tailPtr - headPtr;
  assign full    = occ == PTR_W'(DEPTH);
  assign empty   = occ == '0;
  assign excNow  = headExc;
  assign misNow  = brValid & brMispredict & brHit & ~excNow;
  assign brOff   = brTag - headIdx;

  always_comb begin
    logic run;
    run    = 1'b1;
    retCnt = '0;
    for (int k = 0; k < LANES; k++) begin
      run = run & headElig[k];
      if (run) retCnt = retCnt + LANE_W'(1);
    end
  end

  always_comb begin
    freeSlots = CNT_W'(DEPTH) - CNT_W'(occ) + CNT_W'(retCnt);
    if (excNow || misNow)                 accept = '0;
    else if (CNT_W'(dispNum) <= freeSlots) accept = dispNum;
    else                                   accept = LANE_W'(freeSlots);
  end

  always_comb begin
    ctl.flushAll = excNow;
    ctl.flushYng = misNow;
    ctl.allocCnt = accept;
    ctl.retCnt   = retCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
    end else if (excNow) begin
      tailPtr <= headPtr;
    end else begin
      headPtr <= headPtr + PTR_W'(retCnt);
      if (misNow) tailPtr <= headPtr + PTR_W'(brOff) + PTR_W'(1);
      else        tailPtr <= tailPtr + PTR_W'(accept);
    end
  end

  // R1
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    occ <= PTR_W'(DEPTH));
  // R1
  full_refuse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (full && retCnt == '0) |-> accept == '0);
  // R2
  grant_le_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept <= dispNum);
  // R9
  exc_noret_chk: assert property (@(posedge clk) disable iff (!rstN)
    excNow |-> retCnt == '0);
  // R9
  exc_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    excNow |=> empty);
  // R7
  mis_tail_chk: assert property (@(posedge clk) disable iff (!rstN)
    misNow |=> occ == PTR_W'($past(brOff)) + PTR_W'(1) - PTR_W'($past(retCnt)));
endmodule

// File: rtl/retire_queue.sv
module retire_queue
  import rq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LANE_W-1:0] dispNum,
  input  logic [LANES-1:0]  dispBranch,
  output logic [LANE_W-1:0] dispAccept,
  output logic [IDX_W-1:0]  dispTag,
  input  logic              finValid,
  input  logic [IDX_W-1:0]  finTag,
  input  logic              finExc,
  input  logic              brValid,
  input  logic [IDX_W-1:0]  brTag,
  input  logic              brMispredict,
  output logic [LANE_W-1:0] retCount,
  output logic [IDX_W-1:0]  retTag,
  output logic              excValid,
  output logic [IDX_W-1:0]  excTag,
  output logic              full,
  output logic              empty
);
  ctlStrobe_t       ctl;
  logic [IDX_W-1:0] headIdx, tailIdx;
  logic [LANES-1:0] headElig;
  logic             headExc, brHit;

  rq_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) ctrl_i (
    .clk, .rstN, .dispNum, .brValid, .brMispredict, .brTag, .brHit,
    .headElig, .headExc, .ctl, .headIdx, .tailIdx, .full, .empty
  );

  rq_entries #(.DEPTH(DEPTH), .IDX_W(IDX_W)) entries_i (
    .clk, .rstN, .ctl, .headIdx, .tailIdx, .dispBranch, .finValid, .finTag,
    .finExc, .brValid, .brTag, .headElig, .headExc, .brHit
  );

  assign dispAccept = ctl.allocCnt;
  assign dispTag    = tailIdx;
  assign retCount   = ctl.retCnt;
  assign retTag     = headIdx;
  assign excValid   = ctl.flushAll;
  assign excTag     = headIdx;
endmodule

// File: tb/retire_queue_tb.sv
`timescale 1ns/1ps
module retire_queue_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] dispNum = '0;
  logic [2:0] dispBranch = '0;
  logic [1:0] dispAccept, retCount;
  logic [3:0] dispTag, finTag = '0, brTag = '0, retTag, excTag;
  logic       finValid = 1'b0, finExc = 1'b0, brValid = 1'b0, brMispredict = 1'b0;
  logic       excValid, full, empty;

  always #2.5 clk = ~clk;

  retire_queue dut_i (
    .clk, .rstN, .dispNum, .dispBranch, .dispAccept, .dispTag, .finValid,
    .finTag, .finExc, .brValid, .brTag, .brMispredict, .retCount, .retTag,
    .excValid, .excTag, .full, .empty
  );

  int nChecks = 0, nFail = 0;
  bit doneFlag = 0;
  bit mV[16], mD[16], mE[16], mB[16], mR[16];
  int mHead = 0, mCnt = 0;
  int sbQ[$];

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int dn, input logic [2:0] db, input logic fv, input int ft,
                      input logic fe, input logic bv, input int bt, input logic bm);
    int tail, eRet, eAcc, freeN, oh, oc;
    bit eExc, eMis;
    @(negedge clk);
    dispNum = 2'(dn); dispBranch = db; finValid = fv; finTag = 4'(ft); finExc = fe;
    brValid = bv; brTag = 4'(bt); brMispredict = bm;
    #1;
    tail = (mHead + mCnt) % 16;
    eExc = mV[mHead] && mD[mHead] && mE[mHead];
    eRet = 0;
    if (!eExc) begin
      for (int k = 0; k < 3; k++) begin
        int ix = (mHead + k) % 16;
        if (k < mCnt && mD[ix] && !mE[ix] && (!mB[ix] || mR[ix])) eRet++;
        else break;
      end
    end
    eMis = bv && bm && mV[bt] && mB[bt] && !eExc;
    freeN = 16 - mCnt + eRet;
    eAcc = (eExc || eMis) ? 0 : ((dn < freeN) ? dn : freeN);
    chk("R2 dispAccept", int'(dispAccept), eAcc);
    chk("R2 R7 dispTag", int'(dispTag), tail);
    // R3 R4 R6 R8: retire run length from the reference model
    chk("R3 R4 R6 R8 retCount", int'(retCount), eRet);
    chk("R5 retTag", int'(retTag), mHead);
    chk("R9 excValid", int'(excValid), int'(eExc));
    if (eExc) chk("R9 excTag", int'(excTag), mHead);
    chk("R1 full", int'(full), int'(mCnt == 16));
    chk("R1 empty", int'(empty), int'(mCnt == 0));
    // scoreboard monitor: retired slots leave in dispatch order (R5)
    for (int k = 0; k < int'(retCount); k++) begin
      if (sbQ.size() == 0) chk("R5 scoreboard underflow", 1, 0);
      else chk("R5 retire order", (int'(retTag) + k) % 16, sbQ.pop_front());
    end
    @(posedge clk);
    if (eExc) begin
      for (int i = 0; i < 16; i++) mV[i] = 0;
      mCnt = 0;
      sbQ.delete();
    end else begin
      oh = mHead; oc = mCnt;
      for (int k = 0; k < eRet; k++) mV[(oh + k) % 16] = 0;
      if (eMis) begin
        int bo = (bt - oh + 16) % 16;
        for (int o = bo + 1; o < oc; o++) begin
          mV[(oh + o) % 16] = 0;
          if (sbQ.size() > 0) void'(sbQ.pop_back());
        end
        mCnt = bo + 1 - eRet;
        mR[bt] = 1;
      end else begin
        mCnt = oc - eRet;
      end
      mHead = (oh + eRet) % 16;
      if (fv && mV[ft]) begin mD[ft] = 1; mE[ft] = fe; end
      if (bv && !bm && mV[bt] && mB[bt]) mR[bt] = 1;
      for (int k = 0; k < eAcc; k++) begin
        int ix = (tail + k) % 16;
        mV[ix] = 1; mD[ix] = 0; mE[ix] = 0; mB[ix] = db[k]; mR[ix] = 0;
        sbQ.push_back(ix);
        mCnt++;
      end
    end
  endtask

  task automatic finish_run();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin mV[i] = 0; mD[i] = 0; mE[i] = 0; mB[i] = 0; mR[i] = 0; end
    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    // R10 reset state
    chk("R10 empty after reset", int'(empty), 1);
    chk("R10 full after reset", int'(full), 0);
    chk("R10 retCount after reset", int'(retCount), 0);
    chk("R10 excValid after reset", int'(excValid), 0);
    @(posedge clk);

    step(0, 3'b000, 1, 5, 0, 0, 0, 0);              // R8 finish to unheld slot 5
    repeat (5) step(3, 3'b000, 0, 0, 0, 0, 0, 0);   // slots 0..14
    step(3, 3'b000, 0, 0, 0, 0, 0, 0);              // R1 only one fits
    step(3, 3'b000, 1, 2, 0, 0, 0, 0);              // R1 full: refused; finish out of order
    step(0, 3'b000, 1, 0, 0, 0, 0, 0);
    step(0, 3'b000, 1, 1, 0, 0, 0, 0);              // R3 visible next cycle
    step(3, 3'b000, 0, 0, 0, 0, 0, 0);              // R4 three retire, R2 three refill
    step(0, 3'b000, 1, 3, 0, 0, 0, 0);
    step(0, 3'b000, 1, 4, 0, 0, 0, 0);
    step(0, 3'b000, 0, 0, 0, 0, 0, 0);              // R3 stop at unfinished 5 (R8)
    step(0, 3'b000, 1, 5, 1, 0, 0, 0);              // exception on 5
    step(3, 3'b000, 0, 0, 0, 0, 0, 0);              // R9 flush, dispatch refused
    step(0, 3'b000, 0, 0, 0, 0, 0, 0);              // R9 empty
    step(3, 3'b001, 0, 0, 0, 0, 0, 0);              // slots 5..7, 5 is a branch
    step(0, 3'b000, 1, 5, 0, 0, 0, 0);
    step(0, 3'b000, 1, 6, 0, 0, 0, 0);
    step(0, 3'b000, 1, 7, 0, 0, 0, 0);
    repeat (2) step(0, 3'b000, 0, 0, 0, 0, 0, 0);   // R6 branch unresolved: held
    step(0, 3'b000, 0, 0, 0, 1, 5, 0);              // R6 resolved correctly
    step(0, 3'b000, 0, 0, 0, 0, 0, 0);
    step(3, 3'b010, 0, 0, 0, 0, 0, 0);              // slots 8..10, 9 is a branch
    step(3, 3'b000, 1, 10, 0, 1, 9, 1);             // R7 mispredict, R8 finish to flushed 10
    step(2, 3'b000, 0, 0, 0, 0, 0, 0);              // R7 refill from slot 10

    for (int cyc = 0; cyc < 3000; cyc++) begin
      int dn = $urandom % 4;
      logic [2:0] db = 3'($urandom % 8) & 3'($urandom % 8);
      logic fv = 0, fe = 0, bv = 0, bm = 0;
      int ft = 0, bt = 0;
      int st = $urandom % 16;
      if ($urandom % 10 == 0) begin
        for (int j = 0; j < 16; j++) if (!mV[(st + j) % 16]) begin fv = 1; ft = (st + j) % 16; break; end
      end else if ($urandom % 3 != 0) begin
        for (int j = 0; j < 16; j++) begin
          int ix = (st + j) % 16;
          if (mV[ix] && !mD[ix]) begin fv = 1; ft = ix; fe = ($urandom % 25 == 0); break; end
        end
      end
      if ($urandom % 3 == 0) begin
        st = $urandom % 16;
        for (int j = 0; j < 16; j++) begin
          int ix = (st + j) % 16;
          if (mV[ix] && mB[ix] && !mR[ix]) begin bv = 1; bt = ix; bm = ($urandom % 3 == 0); break; end
        end
      end
      step(dn, db, fv, ft, fe, bv, bt, bm);
    end
    finish_run();
  end
endmodule